// File: doc/BRIEF.md
# Memory-Mapped I/O Address Decoder

This block is a bus slave for a 16-bit, byte-addressable address space. Every access gives an address, write data, an access size (byte or 16-bit word), a read/write direction and an active-low select. The top 4 KiB page of the space, 0xF000 to 0xFFFF (octal 170000 to 177777), is kept for device registers. Memory never responds to an address in that page. Every address below 0xF000 belongs to the RAM region.

The RAM region is backed by an internal byte array of `MEM_BYTES` bytes. The array is built as two byte lanes, selected by address bit 0. Addresses from `MEM_BYTES` up to 0xEFFF are part of the RAM region but hold no storage: they read as zero and drop writes. The I/O page holds three 16-bit registers: a control/status register, a data buffer A and a data buffer B. Bit 15 of the control/status register is a read-only status flag that tells software buffer A holds new data. Any other address in the I/O page is unmapped, and an access to it is reported on an error output.

Reads return data one clock after the access. The same applies to the two error flags.

Top module: `mmio_bus_decoder`

## Requirements
- R1: After reset, `rdata_o`, `unmapped_o` and `align_err_o` are 0, and all three device registers read as 0x0000.
- R2: While `sel_ni` is 1, nothing is stored, `rdata_o` keeps its value and both error flags are 0 one cycle later, whatever `rw_i` is (`rw_i`=1 means read, 0 means write).
- R3: A word access (`word_i`=1) at an even address Z below `MEM_BYTES` is little-endian: bits 7:0 hold byte Z and bits 15:8 hold byte Z+1. Read data appears on `rdata_o` after the next rising clock edge.
- R4: A byte access (`word_i`=0) writes only `wdata_i[7:0]` into the single addressed byte. A byte read returns that byte in `rdata_o[7:0]` with bits 15:8 zero.
- R5: Addresses from `MEM_BYTES` to 0xEFFF read as zero, ignore writes and raise no error flag.
- R6: An access at or above 0xF000 never changes the RAM array, including addresses whose low bits match a populated RAM address.
- R7: The control/status register is at 0xFE70 (octal 177160), buffer A at 0xFE72 (octal 177162) and buffer B at 0xFE74 (octal 177164). Each register is read/write storage. The odd address of each register selects its bits 15:8.
- R8: Control/status bit 15 is set by any write to buffer A and cleared by any read of buffer A. Writes to control/status bit 15 are ignored.
- R9: An access to an I/O-page address outside the three registers raises `unmapped_o` for the one cycle after the access. Such a read returns 0 and such a write changes nothing.
- R10: A word access at an odd address raises `align_err_o` for the one cycle after the access. It writes nothing, and a misaligned read returns 0. `unmapped_o` stays 0 for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Access select, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| word_i | input | 1 | 1 = 16-bit word access, 0 = byte access |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 16 | Write data (bits 7:0 only for a byte access) |
| rdata_o | output | 16 | Registered read data |
| unmapped_o | output | 1 | Unmapped I/O access, one-cycle pulse |
| align_err_o | output | 1 | Misaligned word access, one-cycle pulse |

## Verification
The bench targets the following corner cases. Each is listed with the symptom a wrong design would show:

- **Lane order.** If the lanes are swapped, little-endian word reads come back byte-reversed. If a byte write spills into the neighbouring lane, the byte next to it is corrupted.
- **I/O page aliasing.** I/O-page writes go to 0xF000 and 0xF040, whose low bits equal 0. If the RAM index is truncated without checking the region, RAM address 0 is overwritten.
- **Register neighbours.** An address sweep around the register block checks that only the three register addresses respond. A loose compare would either wrongly raise `unmapped_o` or let a neighbouring address hit a register.
- **Status flag and misaligned writes.** The bench checks that status bit 15 sets on a buffer A write, clears on a buffer A read, and survives a control/status write. It also checks that a misaligned word write leaves both bytes it would have touched intact.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam logic [ADDR_W-1:0] IO_BASE   = 16'o170000;
  localparam logic [ADDR_W-1:0] CSR_ADDR  = 16'o177160;
  localparam logic [ADDR_W-1:0] BUFA_ADDR = 16'o177162;
  localparam logic [ADDR_W-1:0] BUFB_ADDR = 16'o177164;
  localparam int unsigned STAT_BIT = 15;

  typedef enum logic [1:0] {
    DEV_CSR  = 2'd0,
    DEV_BUFA = 2'd1,
    DEV_BUFB = 2'd2,
    DEV_NONE = 2'd3
  } dev_sel_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  output logic              is_io_o,
  output logic              mem_hit_o,
  output dev_sel_e          dev_o,
  output logic              misalign_o
);
  localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W+1)'(MEM_BYTES);

  always_comb begin
    is_io_o    = addr_i >= IO_BASE;
    mem_hit_o  = !is_io_o && ({1'b0, addr_i} < MEM_LIM);
    misalign_o = word_i && addr_i[0];
    dev_o      = DEV_NONE;
    if (is_io_o) begin
      if (addr_i[ADDR_W-1:1] == CSR_ADDR[ADDR_W-1:1])       dev_o = DEV_CSR;
      else if (addr_i[ADDR_W-1:1] == BUFA_ADDR[ADDR_W-1:1]) dev_o = DEV_BUFA;
      else if (addr_i[ADDR_W-1:1] == BUFB_ADDR[ADDR_W-1:1]) dev_o = DEV_BUFB;
    end
  end
endmodule

// File: rtl/mmio_ram_lane.sv
module mmio_ram_lane #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wbyte_i,
  output logic [7:0]       rbyte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wbyte_i;
  end

  assign rbyte_o = mem_q[idx_i];
endmodule

// File: rtl/mmio_io_regs.sv
module mmio_io_regs
  import mmio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  dev_sel_e          dev_i,
  input  logic              word_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [STAT_BIT-1:0] csr_q;
  logic                stat_q;
  logic [DATA_W-1:0]   bufa_q, bufb_q;
  logic                be_lo, be_hi;
  logic [7:0]          wb_lo, wb_hi;

  assign be_lo = word_i || !hi_i;
  assign be_hi = word_i || hi_i;
  assign wb_lo = wdata_i[7:0];
  assign wb_hi = word_i ? wdata_i[15:8] : wdata_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q  <= '0;
      stat_q <= 1'b0;
      bufa_q <= '0;
      bufb_q <= '0;
    end else begin
      if (wr_i) begin
        unique case (dev_i)
          DEV_CSR: begin
            if (be_lo) csr_q[7:0]  <= wb_lo;
            if (be_hi) csr_q[14:8] <= wb_hi[6:0];
          end
          DEV_BUFA: begin
            if (be_lo) bufa_q[7:0]  <= wb_lo;
            if (be_hi) bufa_q[15:8] <= wb_hi;
            stat_q <= 1'b1;
          end
          DEV_BUFB: begin
            if (be_lo) bufb_q[7:0]  <= wb_lo;
            if (be_hi) bufb_q[15:8] <= wb_hi;
          end
          default: ;
        endcase
      end
      if (rd_i && dev_i == DEV_BUFA) stat_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (dev_i)
      DEV_CSR:  rdata_o = {stat_q, csr_q};
      DEV_BUFA: rdata_o = bufa_q;
      DEV_BUFB: rdata_o = bufb_q;
      default:  rdata_o = '0;
    endcase
  end

  // R8
  stat_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && dev_i == DEV_CSR) |=> $stable(stat_q));

  // R9
  unmapped_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && dev_i == DEV_NONE) |=>
      ($stable(csr_q) && $stable(stat_q) && $stable(bufa_q) && $stable(bufb_q)));
endmodule

// File: rtl/mmio_bus_decoder.sv
module mmio_bus_decoder
  import mmio_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              rw_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              unmapped_o,
  output logic              align_err_o
);
  localparam int unsigned LANE_DEPTH = MEM_BYTES / LANES;
  localparam int unsigned IDX_W      = $clog2(LANE_DEPTH);
  localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W+1)'(MEM_BYTES);

  logic     acc, wr, rd;
  logic     is_io, mem_hit, misalign;
  dev_sel_e dev;
  logic [DATA_W-1:0] io_rdata, src, rd_val;
  logic [7:0] lane_rb [LANES];
  logic [DATA_W-1:0] rdata_q;
  logic unmapped_q, align_q;

  assign acc = !sel_ni;
  assign wr  = acc && !rw_i;
  assign rd  = acc && rw_i;

  mmio_addr_decode #(.MEM_BYTES(MEM_BYTES)) u_dec (
    .addr_i    (addr_i),
    .word_i    (word_i),
    .is_io_o   (is_io),
    .mem_hit_o (mem_hit),
    .dev_o     (dev),
    .misalign_o(misalign)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       sel_l, we_l;
    logic [7:0] wb_l;
    assign sel_l = word_i || ((l == 0) ? !addr_i[0] : addr_i[0]);
    assign we_l  = wr && mem_hit && !misalign && sel_l;
    assign wb_l  = (l == 0 || !word_i) ? wdata_i[7:0] : wdata_i[15:8];
    mmio_ram_lane #(.DEPTH(LANE_DEPTH)) u_lane (
      .clk_i  (clk_i),
      .we_i   (we_l),
      .idx_i  (addr_i[IDX_W:1]),
      .wbyte_i(wb_l),
      .rbyte_o(lane_rb[l])
    );
  end

  mmio_io_regs u_io (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr && is_io && !misalign),
    .rd_i   (rd && is_io && !misalign),
    .dev_i  (dev),
    .word_i (word_i),
    .hi_i   (addr_i[0]),
    .wdata_i(wdata_i),
    .rdata_o(io_rdata)
  );

  always_comb begin
    if (mem_hit)    src = {lane_rb[1], lane_rb[0]};
    else if (is_io) src = io_rdata;
    else            src = '0;
    if (misalign)    rd_val = '0;
    else if (word_i) rd_val = src;
    else             rd_val = {8'h00, addr_i[0] ? src[15:8] : src[7:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      unmapped_q <= 1'b0;
      align_q    <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_val;
      unmapped_q <= acc && is_io && !misalign && dev == DEV_NONE;
      align_q    <= acc && misalign;
    end
  end

  assign rdata_o     = rdata_q;
  assign unmapped_o  = unmapped_q;
  assign align_err_o = align_q;

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> ($stable(rdata_o) && !unmapped_o && !align_err_o));

  // R10
  misalign_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && rw_i && word_i && addr_i[0]) |=> (align_err_o && rdata_o == '0));

  // R10
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unmapped_o && align_err_o));

  // R5
  hole_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && rw_i && !(word_i && addr_i[0]) && {1'b0, addr_i} >= MEM_LIM
     && addr_i < IO_BASE) |=> (rdata_o == '0 && !unmapped_o));
endmodule

// File: tb/mmio_bus_decoder_tb_top.sv
module mmio_bus_decoder_tb_top;
  localparam int MB = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sel_ni, rw_i, word_i;
  logic [15:0] addr_i, wdata_i, rdata_o;
  logic unmapped_o, align_err_o;

  always #10 clk_i = ~clk_i;

  mmio_bus_decoder #(.MEM_BYTES(MB)) dut_i (.*);

  int checks = 0, failures = 0;
  logic [7:0]  mem_m [MB];
  logic [14:0] csr_m = '0;
  logic        st_m = 1'b0;
  logic [15:0] bufa_m = '0, bufb_m = '0, last_exp = '0;

  function automatic logic [15:0] half_m(logic [15:0] a);
    int b = int'(a & 16'hFFFE);
    if (b < MB) return {mem_m[b+1], mem_m[b]};
    if (a < 16'hF000) return 16'h0000;
    case (b)
      16'hFE70: return {st_m, csr_m};
      16'hFE72: return bufa_m;
      16'hFE74: return bufb_m;
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic put_byte(logic [15:0] a, logic [7:0] v);
    if (int'(a) < MB) mem_m[a] = v;
    else case (a)
      16'hFE70: csr_m[7:0]  = v;
      16'hFE71: csr_m[14:8] = v[6:0];
      16'hFE72: begin bufa_m[7:0]  = v; st_m = 1'b1; end
      16'hFE73: begin bufa_m[15:8] = v; st_m = 1'b1; end
      16'hFE74: bufb_m[7:0]  = v;
      16'hFE75: bufb_m[15:8] = v;
      default: ;
    endcase
  endtask

  task automatic xfer(string req, bit rw, bit word, logic [15:0] a, logic [15:0] wd);
    logic [15:0] h, exp_rd;
    logic [15:0] b;
    bit exp_al, exp_un, is_reg;
    b      = a & 16'hFFFE;
    exp_al = word && a[0];
    is_reg = (b == 16'hFE70) || (b == 16'hFE72) || (b == 16'hFE74);
    exp_un = !exp_al && a >= 16'hF000 && !is_reg;
    exp_rd = last_exp;
    if (rw) begin
      h = half_m(a);
      exp_rd = exp_al ? 16'h0 : word ? h : {8'h00, a[0] ? h[15:8] : h[7:0]};
      if (!exp_al && b == 16'hFE72) st_m = 1'b0;
    end else if (!exp_al) begin
      if (word) begin put_byte(a, wd[7:0]); put_byte(a + 16'd1, wd[15:8]); end
      else put_byte(a, wd[7:0]);
    end
    @(negedge clk_i);
    sel_ni = 1'b0; rw_i = rw; word_i = word; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    checks++;
    if (rdata_o !== exp_rd || unmapped_o !== exp_un || align_err_o !== exp_al) begin
      failures++;
      $display("FAIL %s addr=%h rdata=%h exp=%h unmapped=%b exp=%b align=%b exp=%b",
               req, a, rdata_o, exp_rd, unmapped_o, exp_un, align_err_o, exp_al);
    end
    sel_ni = 1'b1;
    last_exp = exp_rd;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    sel_ni = 1'b1; rw_i = 1'b1; word_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    checks++;
    if (rdata_o !== 16'h0 || unmapped_o !== 1'b0 || align_err_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 rdata=%h exp=0000 unmapped=%b align=%b exp=0", rdata_o, unmapped_o, align_err_o);
    end
    xfer("R1", 1, 1, 16'hFE70, 0);
    xfer("R1", 1, 1, 16'hFE72, 0);
    xfer("R1", 1, 1, 16'hFE74, 0);

    // R3 little-endian words over the whole array
    for (int a = 0; a < MB; a += 2) xfer("R3", 0, 1, 16'(a), 16'(a * 16'h0203) ^ 16'hA55A);
    for (int a = 0; a < MB; a += 2) xfer("R3", 1, 1, 16'(a), 0);
    // R4 byte lanes
    for (int a = 0; a < MB; a++) xfer("R4", 1, 0, 16'(a), 0);
    for (int a = 1; a < MB; a += 2) xfer("R4", 0, 0, 16'(a), {8'hEE, ~8'(a)});
    for (int a = 0; a < MB; a += 2) xfer("R4", 1, 1, 16'(a), 0);

    // R5 unpopulated RAM region
    xfer("R5", 0, 1, 16'd64, 16'h1111);
    xfer("R5", 0, 0, 16'd1001, 16'h0022);
    xfer("R5", 0, 1, 16'hEFFE, 16'h3333);
    xfer("R5", 1, 1, 16'd64, 0);
    xfer("R5", 1, 0, 16'd1001, 0);
    xfer("R5", 1, 1, 16'hEFFE, 0);
    xfer("R5", 1, 1, 16'd0, 0);

    // R6 I/O page aliasing onto low RAM bits
    xfer("R6", 0, 1, 16'hF000, 16'hBEEF);
    xfer("R6", 0, 1, 16'hF040, 16'hCAFE);
    xfer("R6", 0, 0, 16'hFF80, 16'h0077);
    xfer("R6", 1, 1, 16'd0, 0);

    // R7 register storage and byte halves
    xfer("R7", 0, 1, 16'hFE70, 16'hFFFF);
    xfer("R7", 1, 1, 16'hFE70, 0);
    xfer("R7", 0, 1, 16'hFE74, 16'h5AA5);
    xfer("R7", 0, 0, 16'hFE75, 16'h003C);
    xfer("R7", 1, 1, 16'hFE74, 0);
    xfer("R7", 1, 0, 16'hFE75, 0);
    xfer("R7", 1, 0, 16'hFE74, 0);

    // R8 status bit
    xfer("R8", 0, 1, 16'hFE72, 16'h1234);
    xfer("R8", 1, 1, 16'hFE70, 0);
    xfer("R8", 1, 1, 16'hFE72, 0);
    xfer("R8", 1, 1, 16'hFE70, 0);
    xfer("R8", 0, 0, 16'hFE73, 16'h0099);
    xfer("R8", 0, 1, 16'hFE70, 16'h0000);
    xfer("R8", 1, 1, 16'hFE70, 0);
    xfer("R8", 1, 0, 16'hFE73, 0);
    xfer("R8", 1, 1, 16'hFE70, 0);

    // R9 sweep around the register block
    for (int a = 16'hFE60; a < 16'hFE80; a += 2) xfer("R9", 0, 1, 16'(a), 16'hDEAD);
    for (int a = 16'hFE60; a < 16'hFE80; a += 2) xfer("R9", 1, 1, 16'(a), 0);
    xfer("R9", 1, 0, 16'hFFFF, 0);

    // R10 misaligned words
    xfer("R10", 0, 1, 16'd5, 16'hFFFF);
    xfer("R10", 1, 1, 16'd4, 0);
    xfer("R10", 1, 1, 16'd6, 0);
    xfer("R10", 1, 1, 16'd7, 0);
    xfer("R10", 1, 1, 16'hFE71, 0);
    xfer("R10", 0, 1, 16'hFE75, 16'h0101);
    xfer("R10", 1, 1, 16'hFE74, 0);

    // R2 deselected write
    @(negedge clk_i);
    sel_ni = 1'b1; rw_i = 1'b0; word_i = 1'b1; addr_i = 16'd0; wdata_i = 16'hFFFF;
    @(negedge clk_i);
    checks++;
    if (rdata_o !== last_exp || unmapped_o !== 1'b0 || align_err_o !== 1'b0) begin
      failures++;
      $display("FAIL R2 rdata=%h exp=%h unmapped=%b align=%b exp=0", rdata_o, last_exp, unmapped_o, align_err_o);
    end
    xfer("R2", 1, 1, 16'd0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule